// File: doc/BRIEF.md
# Per-Core Interrupt Enable and Pending Unit

This block gathers a vector of level-sensitive device interrupt lines and drives one interrupt request line to each of up to eight processor cores. Every core owns a private enable mask. It also owns a pending view that software can only read. Both sit in a small window of the control-register address space. A plain read/write port reaches them. The port carries an address, write data and a write strobe, and it returns read data in the same cycle.

A core's request is the OR of the sources that core has enabled. There is no priority, no claim step and no latched state. Once a source is enabled, its request follows the device line. The request stays high until the device withdraws its line or software clears the enable bit. Source lines pass through a two-stage synchronizer before masking, and the request output is registered, so the latency from a source change to the request is fixed.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset every enable mask reads zero, every pending view reads zero and every request output is low.
- R2: The enable mask for core i is read and written at address 0x7C0 + 2*i. Only the low NUM_SRC bits are stored, and all higher read-data bits return zero.
- R3: The pending view for core i is read at address 0x7C0 + 2*i + 1. It returns the synchronized source levels ANDed with that core's mask. Reading it changes nothing, so two back-to-back reads return the same value.
- R4: A write to any pending address leaves every enable mask unchanged.
- R5: Request output bit i is high exactly when the pending view of core i was non-zero one clock earlier.
- R6: A source change driven between two rising edges appears in the pending view after the second following rising edge, and on the request output after the third.
- R7: The request stays high while an enabled source stays high. It falls three edges after the source is released, or one edge after the write that clears the enable bit.
- R8: A write to one core's enable address leaves the masks of all other cores unchanged. A source enabled only for one core raises only that core's request.
- R9: An address outside the window 0x7C0 to 0x7C0 + 2*NUM_CORES - 1 reads as zero, and a write to such an address changes no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive device interrupt lines, asynchronous |
| reg_addr_i | input | ADDR_W | Control-register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_we_i | input | 1 | Write strobe; the write takes effect at the rising edge |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, same cycle |
| irq_o | output | NUM_CORES | Registered interrupt request, one bit per core |

## Verification
Read data is combinational, so each register read is sampled at the falling edge after the address is driven. An enable write lands at the rising edge that samples the strobe. A source change driven between edges reaches the pending view two rising edges later and the request output three rising edges later. The bench drives every stimulus just after a falling edge and counts rising edges from that point. It samples one time unit after the edge where the result is due, and also checks the edges before it, so an early result is caught as well as a late one. A cleared enable is checked one edge after its write.

// File: rtl/irqm_pkg.sv
// Package: irqm_pkg
// Shared constants and types for the per-core interrupt mask unit.
// Assumes that the slot offset inside the window has its low bit set for a
// pending slot and clear for an enable slot.
package irqm_pkg;

    // Largest supported core count
    localparam int unsigned MAX_CORES = 8;

    // Kind of register addressed inside the window (bit 0 of the offset)
    typedef enum logic {
        SLOT_ENABLE  = 1'b0,
        SLOT_PENDING = 1'b1
    } slot_kind_e;

endpackage

// File: rtl/irqm_sync.sv
// Module: irqm_sync
// Two-stage synchronizer for a vector of asynchronous level inputs.
// Assumes that each bit is an independent slow level, so no bus coherence is
// required across bits.
module irqm_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw levels through two flops; both clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/irqm_decode.sv
// Module: irqm_decode
// Decodes a control-register address into window hit, core index and slot
// kind. Purely combinational.
// Assumes that the window holds two slots per configured core, starting at
// WIN_BASE, and that it does not wrap past the top of the address space.
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int unsigned          NUM_CORES = 8,
    parameter int unsigned          ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]    WIN_BASE  = 12'h7C0,
    localparam int unsigned         CIDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [CIDX_W-1:0] core_o,
    output slot_kind_e        kind_o
);

    localparam logic [ADDR_W-1:0] SLOT_COUNT = ADDR_W'(2 * NUM_CORES);

    logic [ADDR_W-1:0] offset;

    // Offset of the address from the window base
    always_comb begin
        offset = addr_i - WIN_BASE;
    end

    // Window hit, core select and slot kind from the offset
    always_comb begin
        hit_o  = (addr_i >= WIN_BASE) && (offset < SLOT_COUNT);
        core_o = CIDX_W'(offset >> 1);
        kind_o = slot_kind_e'(offset[0]);
    end

endmodule

// File: rtl/irqm_enable_bank.sv
// Module: irqm_enable_bank
// Holds one NUM_SRC-bit enable mask per core. A write lands in the mask of
// the selected core only when the address hits an enable slot.
// Assumes that NUM_SRC <= DATA_W, so that the low bits of the write data fill
// the mask.
module irqm_enable_bank
    import irqm_pkg::*;
#(
    parameter int unsigned  NUM_CORES = 8,
    parameter int unsigned  NUM_SRC   = 8,
    parameter int unsigned  DATA_W    = 32,
    localparam int unsigned CIDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic                         hit_i,
    input  logic [CIDX_W-1:0]            core_i,
    input  slot_kind_e                   kind_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [NUM_CORES*NUM_SRC-1:0] en_flat_o
);

    logic wr_enable_slot;

    // A write is accepted only for an enable slot inside the window
    always_comb begin
        wr_enable_slot = we_i && hit_i && (kind_i == SLOT_ENABLE);
    end

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core_mask
        logic [NUM_SRC-1:0] mask_q;

        // Per-core mask register; clears on reset, loads on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (wr_enable_slot && (core_i == CIDX_W'(k))) begin
                mask_q <= wdata_i[NUM_SRC-1:0];
            end
        end

        assign en_flat_o[k*NUM_SRC +: NUM_SRC] = mask_q;
    end

endmodule

// File: rtl/irqm_core_slice.sv
// Module: irqm_core_slice
// Masks the synchronized sources with one core's enables, exposes the result
// as the pending view and registers its OR as the core's request.
// Assumes that the sources are already synchronous to clk.
module irqm_core_slice #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_sync_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               irq_o
);

    logic irq_q;

    // Pending view: live source levels gated by this core's mask
    always_comb begin
        pending_o = src_sync_i & enable_i;
    end

    // Registered request: high whenever any enabled source is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pending_o;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_mask_unit.sv
// Module: irq_mask_unit (top)
// Per-core interrupt enable/pending unit. It synchronizes the device lines,
// masks them per core, drives one registered request per core and serves
// enable and pending registers through a simple read/write port.
// Assumes level-sensitive sources, NUM_CORES <= 8 and NUM_SRC <= DATA_W.
// Read data is combinational from the address.
module irq_mask_unit
    import irqm_pkg::*;
#(
    parameter int unsigned       NUM_CORES = 8,
    parameter int unsigned       NUM_SRC   = 8,
    parameter int unsigned       ADDR_W    = 12,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h7C0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    input  logic                 reg_we_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic [NUM_CORES-1:0] irq_o
);

    localparam int unsigned CIDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [NUM_SRC-1:0]           src_sync;
    logic                         dec_hit;
    logic [CIDX_W-1:0]            dec_core;
    slot_kind_e                   dec_kind;
    logic [NUM_CORES*NUM_SRC-1:0] en_flat;
    logic [NUM_CORES*NUM_SRC-1:0] pend_flat;
    logic [NUM_SRC-1:0]           sel_value;

    irqm_sync #(
        .WIDTH (NUM_SRC)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irqm_decode #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE)
    ) u_decode (
        .addr_i (reg_addr_i),
        .hit_o  (dec_hit),
        .core_o (dec_core),
        .kind_o (dec_kind)
    );

    irqm_enable_bank #(
        .NUM_CORES (NUM_CORES),
        .NUM_SRC   (NUM_SRC),
        .DATA_W    (DATA_W)
    ) u_enables (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .hit_i     (dec_hit),
        .core_i    (dec_core),
        .kind_i    (dec_kind),
        .wdata_i   (reg_wdata_i),
        .en_flat_o (en_flat)
    );

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_slice
        irqm_core_slice #(
            .NUM_SRC (NUM_SRC)
        ) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_sync_i (src_sync),
            .enable_i   (en_flat[k*NUM_SRC +: NUM_SRC]),
            .pending_o  (pend_flat[k*NUM_SRC +: NUM_SRC]),
            .irq_o      (irq_o[k])
        );
    end

    // Pick the addressed core's enable mask or pending view
    always_comb begin
        sel_value = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            if (dec_core == CIDX_W'(k)) begin
                sel_value = (dec_kind == SLOT_PENDING)
                          ? pend_flat[k*NUM_SRC +: NUM_SRC]
                          : en_flat[k*NUM_SRC +: NUM_SRC];
            end
        end
    end

    // Zero-extend the selection; anything outside the window reads zero
    always_comb begin
        reg_rdata_o = '0;
        if (dec_hit) begin
            reg_rdata_o[NUM_SRC-1:0] = sel_value;
        end
    end

endmodule

// File: rtl/irqm_checker.sv
// Module: irqm_checker
// Assertion checker for irq_mask_unit, attached by the bind statement at the
// end of this file. It observes the ports plus the enable and pending buses.
module irqm_checker #(
    parameter int unsigned       NUM_CORES = 8,
    parameter int unsigned       NUM_SRC   = 8,
    parameter int unsigned       ADDR_W    = 12,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h7C0
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_SRC-1:0]           src_i,
    input logic [ADDR_W-1:0]            reg_addr_i,
    input logic                         reg_we_i,
    input logic [DATA_W-1:0]            reg_rdata_o,
    input logic [NUM_CORES-1:0]         irq_o,
    input logic [NUM_CORES*NUM_SRC-1:0] en_flat,
    input logic [NUM_CORES*NUM_SRC-1:0] pend_flat
);

    logic [ADDR_W-1:0] chk_off;
    logic              chk_in_win;

    // Independent window decode for the properties
    always_comb begin
        chk_off    = reg_addr_i - WIN_BASE;
        chk_in_win = (reg_addr_i >= WIN_BASE) && (chk_off < ADDR_W'(2 * NUM_CORES));
    end

    // R4
    pending_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && chk_in_win && chk_off[0]) |=> $stable(en_flat));

    // R9
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_in_win |-> (reg_rdata_o == '0));

    // R9
    outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && !chk_in_win) |=> $stable(en_flat));

    // R7
    idle_sources_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_i, 1) == '0 && $past(src_i, 2) == '0 && $past(src_i, 3) == '0)
        |-> (irq_o == '0));

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core_chk
        // R5
        irq_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] == $past(|pend_flat[k*NUM_SRC +: NUM_SRC]));

        // R8
        other_mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we_i && reg_addr_i != (WIN_BASE + ADDR_W'(2 * k)))
            |=> $stable(en_flat[k*NUM_SRC +: NUM_SRC]));
    end

endmodule

bind irq_mask_unit irqm_checker #(
    .NUM_CORES (NUM_CORES),
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_BASE  (WIN_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .en_flat     (en_flat),
    .pend_flat   (pend_flat)
);

// File: tb/irq_mask_unit_tb_top.sv
// Bench for irq_mask_unit: a vector table walked by one loop, then directed
// tests for reset, latency, level behaviour and address corner cases.
module irq_mask_unit_tb_top;

    localparam int unsigned NC = 8;
    localparam int unsigned NS = 8;
    localparam logic [11:0] BASE = 12'h7C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_mask_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_we_i    (we),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Vector fields: core[26:24], enable[23:16], sources[15:8], expected pending[7:0]
    localparam logic [26:0] VEC [8] = '{
        {3'd0, 8'h08, 8'h08, 8'h08},
        {3'd0, 8'h08, 8'hF7, 8'h00},
        {3'd3, 8'hF0, 8'h3C, 8'h30},
        {3'd7, 8'hFF, 8'h81, 8'h81},
        {3'd5, 8'h00, 8'hFF, 8'h00},
        {3'd2, 8'h55, 8'hAA, 8'h00},
        {3'd1, 8'h55, 8'h5F, 8'h55},
        {3'd6, 8'h80, 8'h80, 8'h80}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_src(input logic [7:0] v);
        @(negedge clk);
        src = v;
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int c = 0; c < NC; c++) begin
            rd(BASE + 12'(2 * c), d);
            chk("R1 enable reads zero", d, 32'h0);
            rd(BASE + 12'(2 * c + 1), d);
            chk("R1 pending reads zero", d, 32'h0);
        end

        // Vector loop: R3, R5, R8
        for (int v = 0; v < 8; v++) begin
            logic [2:0] core;
            logic [7:0] en;
            logic [7:0] sv;
            logic [7:0] ep;
            logic [7:0] exp_irq;
            {core, en, sv, ep} = VEC[v];
            exp_irq = (ep != 8'h00) ? (8'h01 << core) : 8'h00;
            wr(BASE + 12'(2 * core), 32'(en));
            set_src(sv);
            tick(3);
            chk("R8 R5 irq vector", 32'(irq), 32'(exp_irq));
            rd(BASE + 12'(2 * core + 1), d);
            chk("R3 pending value", d, 32'(ep));
            set_src(8'h00);
            wr(BASE + 12'(2 * core), 32'h0);
            tick(4);
        end

        // R2: upper bits not stored
        wr(BASE + 12'd8, 32'hFFFF_FFFF);
        rd(BASE + 12'd8, d);
        chk("R2 enable width", d, 32'h0000_00FF);
        wr(BASE + 12'd8, 32'h0);

        // R4: pending write ignored
        wr(BASE + 12'd9, 32'hFF);
        rd(BASE + 12'd8, d);
        chk("R4 enable unchanged", d, 32'h0);
        rd(BASE + 12'd9, d);
        chk("R4 pending unchanged", d, 32'h0);

        // R9: outside the window
        wr(12'h7D0, 32'hFF);
        wr(12'h7BF, 32'hFF);
        rd(12'h7D0, d);
        chk("R9 read above window", d, 32'h0);
        rd(12'h7BF, d);
        chk("R9 read below window", d, 32'h0);
        for (int c = 0; c < NC; c++) begin
            rd(BASE + 12'(2 * c), d);
            chk("R9 masks untouched", d, 32'h0);
        end

        // R6: latency, core 0 enabling source 3 only
        wr(BASE, 32'h08);
        set_src(8'h08);
        tick(1);
        chk("R6 irq after 1 edge", 32'(irq), 32'h0);
        rd(BASE + 12'd1, d);
        chk("R6 pending after 1 edge", d, 32'h0);
        tick(1);
        chk("R6 irq after 2 edges", 32'(irq), 32'h0);
        rd(BASE + 12'd1, d);
        chk("R6 pending after 2 edges", d, 32'h08);
        tick(1);
        chk("R6 irq after 3 edges", 32'(irq), 32'h01);

        // R3: reading has no side effect
        rd(BASE + 12'd1, d);
        rd(BASE + 12'd1, d2);
        chk("R3 repeat read", d2, d);

        // R7: holds while high, drops three edges after release
        tick(20);
        chk("R7 irq held", 32'(irq), 32'h01);
        set_src(8'h00);
        tick(2);
        chk("R7 irq before drop", 32'(irq), 32'h01);
        tick(1);
        chk("R7 irq dropped", 32'(irq), 32'h00);

        // R8: core 1 also enabled; clearing core 0 leaves core 1 alone
        wr(BASE + 12'd2, 32'h08);
        set_src(8'h08);
        tick(3);
        chk("R8 both cores", 32'(irq), 32'h03);
        wr(BASE, 32'h0);
        chk("R7 irq at enable-clear edge", 32'(irq), 32'h03);
        tick(1);
        chk("R7 R8 core 0 dropped only", 32'(irq), 32'h02);
        rd(BASE + 12'd2, d);
        chk("R8 core 1 mask kept", d, 32'h08);

        set_src(8'h00);
        tick(4);
        chk("R7 all quiet", 32'(irq), 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule